// File: doc/BRIEF.md
# Split Read Completion Chunker

This block takes inbound read requests from a bus that uses split transactions. Each request carries a start address, a byte count, a requester tag, attribute bits and a command code. When there is room, the block stores the request and answers the initiator one cycle later with a split-response pulse. That pulse tells the initiator the data will follow in a separate completion. When the request store is full, the block answers with a retry pulse instead and keeps nothing.

Stored requests are served one at a time, in the order they were accepted. The block cuts each request at 1024-byte aligned boundaries and handles one piece (a chunk) at a time:

1. It issues one backend read for the whole chunk.
2. It collects every returned data beat of that chunk in a local buffer.
3. It then streams the chunk out as one completion, a burst of consecutive beats.

A request that stays inside one aligned 1024-byte region therefore gives a single completion, and that completion starts only after its full byte count has come back. A request that crosses boundaries gives one completion per aligned piece.

Data beats are 8 bytes wide. Request addresses and byte counts are multiples of 8, and byte counts run from 8 to 4096.

Top module: `scc_split_chunker`

## Requirements
- R1: A request presented with `req_valid` while fewer than QDEPTH requests are held produces `rsp_split` high for exactly one cycle, in the cycle after the request.
- R2: A request presented while QDEPTH requests are held, including the one being completed, produces `rsp_retry` high for one cycle in the cycle after. Nothing is stored for it, and no completion ever carries its tag.
- R3: `rsp_split` and `rsp_retry` are never high together, and neither is high unless `req_valid` was high in the previous cycle.
- R4: Each chunk is requested from the backend with a one-cycle `be_cmd_valid` pulse. The pulse carries the chunk start address, the chunk byte count and the request's command code. No new backend read is issued before the previous chunk has been fully sent out.
- R5: The first completion beat of a chunk appears only after all of that chunk's data has arrived, which is byte count / 8 cycles with `be_rd_valid` high.
- R6: A request that crosses 1024-byte aligned boundaries is split into chunks in this order:
  - a first chunk from the start address up to the next boundary;
  - zero or more middle chunks of exactly 1024 bytes;
  - a last chunk from the final boundary to the end of the request.
  
  No completion spans a boundary.
- R7: A completion occupies byte count / 8 consecutive cycles of `cpl_valid`. Every beat carries the chunk start address, the chunk byte count, the tag and the attribute bits. `cpl_first` marks the first beat and `cpl_last` the last. Beat k carries the k-th beat returned by the backend for that chunk, so the data is in ascending address order.
- R8: Completions of different requests appear in the order the requests were accepted.
- R9: While reset is asserted, and in the cycles right after its release, `rsp_split`, `rsp_retry`, `be_cmd_valid` and `cpl_valid` are low.
- R10: A request that ends exactly on a 1024-byte boundary, or that covers exactly one aligned 1024-byte block, is completed as a single chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present this cycle |
| req_addr | input | AW | Request start byte address (multiple of 8) |
| req_bcnt | input | BCW | Request byte count (8..4096, multiple of 8) |
| req_tag | input | TW | Requester tag |
| req_attr | input | ATW | Request attribute bits, passed through |
| req_cmd | input | CMW | Request command code, passed to the backend |
| rsp_split | output | 1 | Request accepted, completion will follow |
| rsp_retry | output | 1 | Request refused, store full |
| be_cmd_valid | output | 1 | Backend read pulse for one chunk |
| be_cmd_addr | output | AW | Chunk start address |
| be_cmd_bcnt | output | BCW | Chunk byte count |
| be_cmd_code | output | CMW | Command code of the request |
| be_rd_valid | input | 1 | Backend data beat valid |
| be_rd_data | input | DW | Backend data beat |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_addr | output | AW | Chunk start address of this completion |
| cpl_bcnt | output | BCW | Chunk byte count of this completion |
| cpl_tag | output | TW | Requester tag |
| cpl_attr | output | ATW | Attribute bits of the request |
| cpl_first | output | 1 | First beat of the completion |
| cpl_last | output | 1 | Last beat of the completion |
| cpl_data | output | DW | Completion data beat |

## Verification
The assertions check these rules on every cycle:
- the two response pulses exclude each other and always follow a request;
- backend commands are single-cycle pulses;
- no completion spans a 1024-byte boundary;
- completion beats are back to back;
- a chunk is sent only once its buffer is full;
- the request store is never popped when empty.

Some behaviour is shown only by the bench's scenarios, where a behavioural model predicts every output:
- the exact chunk sizes for each start offset;
- the data order;
- acceptance order across requests;
- the retry threshold as the store fills behind a long request;
- the absence of any completion for a refused request.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ISSUE = 2'd1,
    CS_FILL  = 2'd2,
    CS_SEND  = 2'd3
  } chunk_state_e;

endpackage

// File: rtl/scc_req_queue.sv
module scc_req_queue #(
  parameter int W     = 58,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == LAST_IDX) ? '0 : wptr_q + PW'(1);
    if (pop)  rptr_d = (rptr_q == LAST_IDX) ? '0 : rptr_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= push_data;
  end

  assign head  = mem_q[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);

  // R8: a request leaves the store only when one is held
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0))
    else $error("pop on empty request store");

endmodule

// File: rtl/scc_chunk_buf.sv
module scc_chunk_buf #(
  parameter int DW    = 64,
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] ridx,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wdata;
  end

  assign rdata = mem_q[ridx];

endmodule

// File: rtl/scc_chunk_ctrl.sv
module scc_chunk_ctrl
  import scc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BCW         = 13,
  parameter int TW          = 5,
  parameter int ATW         = 4,
  parameter int CMW         = 4,
  parameter int BEAT_BYTES  = 8,
  parameter int CHUNK_BYTES = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   q_empty,
  input  logic [AW-1:0]          hd_addr,
  input  logic [BCW-1:0]         hd_bcnt,
  input  logic [TW-1:0]          hd_tag,
  input  logic [ATW-1:0]         hd_attr,
  input  logic [CMW-1:0]         hd_cmd,
  output logic                   q_pop,
  output logic                   be_cmd_valid,
  output logic [AW-1:0]          be_cmd_addr,
  output logic [BCW-1:0]         be_cmd_bcnt,
  output logic [CMW-1:0]         be_cmd_code,
  input  logic                   be_rd_valid,
  output logic                   buf_we,
  output logic [$clog2(CHUNK_BYTES/BEAT_BYTES)-1:0] buf_widx,
  output logic [$clog2(CHUNK_BYTES/BEAT_BYTES)-1:0] buf_ridx,
  output logic                   cpl_valid,
  output logic [AW-1:0]          cpl_addr,
  output logic [BCW-1:0]         cpl_bcnt,
  output logic [TW-1:0]          cpl_tag,
  output logic [ATW-1:0]         cpl_attr,
  output logic                   cpl_first,
  output logic                   cpl_last
);
  localparam int CHUNK_BEATS = CHUNK_BYTES / BEAT_BYTES;
  localparam int IW  = $clog2(CHUNK_BEATS);
  localparam int BTW = $clog2(CHUNK_BEATS + 1);
  localparam int BSH = $clog2(BEAT_BYTES);
  localparam int CSH = $clog2(CHUNK_BYTES);
  localparam logic [BCW-1:0] CHUNK_B = BCW'(CHUNK_BYTES);

  chunk_state_e   state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [BCW-1:0] rem_q, rem_d;
  logic [BCW-1:0] clen_q, clen_d;
  logic [TW-1:0]  tag_q, tag_d;
  logic [ATW-1:0] attr_q, attr_d;
  logic [CMW-1:0] code_q, code_d;
  logic [BTW-1:0] wcnt_q, wcnt_d;
  logic [BTW-1:0] rcnt_q, rcnt_d;

  logic [BCW-1:0] room_c, clen_c;
  logic [BTW-1:0] beats_q;
  logic           send_last_c;

  // bytes left before the next aligned boundary, and the chunk size
  assign room_c      = CHUNK_B - BCW'(addr_q[CSH-1:0]);
  assign clen_c      = (rem_q < room_c) ? rem_q : room_c;
  assign beats_q     = BTW'(clen_q >> BSH);
  assign send_last_c = (rcnt_q == beats_q - BTW'(1));

  always_comb begin
    state_d      = state_q;
    addr_d       = addr_q;
    rem_d        = rem_q;
    clen_d       = clen_q;
    tag_d        = tag_q;
    attr_d       = attr_q;
    code_d       = code_q;
    wcnt_d       = wcnt_q;
    rcnt_d       = rcnt_q;
    q_pop        = 1'b0;
    be_cmd_valid = 1'b0;
    buf_we       = 1'b0;
    cpl_valid    = 1'b0;
    case (state_q)
      CS_IDLE: begin
        if (!q_empty) begin
          addr_d  = hd_addr;
          rem_d   = hd_bcnt;
          tag_d   = hd_tag;
          attr_d  = hd_attr;
          code_d  = hd_cmd;
          state_d = CS_ISSUE;
        end
      end
      CS_ISSUE: begin
        be_cmd_valid = 1'b1;
        clen_d       = clen_c;
        wcnt_d       = '0;
        state_d      = CS_FILL;
      end
      CS_FILL: begin
        if (be_rd_valid) begin
          buf_we = 1'b1;
          wcnt_d = wcnt_q + BTW'(1);
          if (wcnt_q + BTW'(1) == beats_q) begin
            rcnt_d  = '0;
            state_d = CS_SEND;
          end
        end
      end
      CS_SEND: begin
        cpl_valid = 1'b1;
        if (send_last_c) begin
          addr_d = addr_q + AW'(clen_q);
          rem_d  = rem_q - clen_q;
          if (rem_q == clen_q) begin
            q_pop   = 1'b1;
            state_d = CS_IDLE;
          end else begin
            state_d = CS_ISSUE;
          end
        end else begin
          rcnt_d = rcnt_q + BTW'(1);
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      clen_q  <= '0;
      tag_q   <= '0;
      attr_q  <= '0;
      code_q  <= '0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      clen_q  <= clen_d;
      tag_q   <= tag_d;
      attr_q  <= attr_d;
      code_q  <= code_d;
      wcnt_q  <= wcnt_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign be_cmd_addr = addr_q;
  assign be_cmd_bcnt = clen_c;
  assign be_cmd_code = code_q;
  assign buf_widx    = IW'(wcnt_q);
  assign buf_ridx    = IW'(rcnt_q);
  assign cpl_addr    = addr_q;
  assign cpl_bcnt    = clen_q;
  assign cpl_tag     = tag_q;
  assign cpl_attr    = attr_q;
  assign cpl_first   = (state_q == CS_SEND) && (rcnt_q == '0);
  assign cpl_last    = (state_q == CS_SEND) && send_last_c;

  // R4: a backend read is a single-cycle pulse
  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    be_cmd_valid |=> !be_cmd_valid)
    else $error("backend command longer than one cycle");

  // R5: sending starts only with every beat of the chunk captured
  p_send_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_first) |-> (wcnt_q == beats_q))
    else $error("completion started before chunk data complete");

  // R6: no completion reaches past an aligned boundary
  p_chunk_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> ((BCW'(cpl_addr[CSH-1:0]) + cpl_bcnt) <= CHUNK_B))
    else $error("completion spans an aligned boundary");

  // R7: completion beats run back to back up to the last one
  p_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_last) |=> cpl_valid)
    else $error("gap inside a completion");

endmodule

// File: rtl/scc_split_chunker.sv
module scc_split_chunker #(
  parameter int AW          = 32,
  parameter int DW          = 64,
  parameter int BCW         = 13,
  parameter int TW          = 5,
  parameter int ATW         = 4,
  parameter int CMW         = 4,
  parameter int QDEPTH      = 4,
  parameter int CHUNK_BYTES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [BCW-1:0]  req_bcnt,
  input  logic [TW-1:0]   req_tag,
  input  logic [ATW-1:0]  req_attr,
  input  logic [CMW-1:0]  req_cmd,
  output logic            rsp_split,
  output logic            rsp_retry,
  output logic            be_cmd_valid,
  output logic [AW-1:0]   be_cmd_addr,
  output logic [BCW-1:0]  be_cmd_bcnt,
  output logic [CMW-1:0]  be_cmd_code,
  input  logic            be_rd_valid,
  input  logic [DW-1:0]   be_rd_data,
  output logic            cpl_valid,
  output logic [AW-1:0]   cpl_addr,
  output logic [BCW-1:0]  cpl_bcnt,
  output logic [TW-1:0]   cpl_tag,
  output logic [ATW-1:0]  cpl_attr,
  output logic            cpl_first,
  output logic            cpl_last,
  output logic [DW-1:0]   cpl_data
);
  localparam int BEAT_BYTES  = DW / 8;
  localparam int CHUNK_BEATS = CHUNK_BYTES / BEAT_BYTES;
  localparam int IW          = $clog2(CHUNK_BEATS);
  localparam int EW          = AW + BCW + TW + ATW + CMW;

  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic          q_push, q_pop, q_empty, q_full;
  logic [EW-1:0] q_head;
  logic [AW-1:0]  hd_addr;
  logic [BCW-1:0] hd_bcnt;
  logic [TW-1:0]  hd_tag;
  logic [ATW-1:0] hd_attr;
  logic [CMW-1:0] hd_cmd;

  logic split_d, retry_d;
  logic split_q, retry_q;

  assign q_push  = req_valid && !q_full;
  assign split_d = q_push;
  assign retry_d = req_valid && q_full;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      split_q <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      split_q <= split_d;
      retry_q <= retry_d;
    end
  end
  assign rsp_split = split_q;
  assign rsp_retry = retry_q;

  scc_req_queue #(.W(EW), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_ns),
    .push      (q_push),
    .push_data ({req_cmd, req_attr, req_tag, req_bcnt, req_addr}),
    .pop       (q_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  assign {hd_cmd, hd_attr, hd_tag, hd_bcnt, hd_addr} = q_head;

  logic          buf_we;
  logic [IW-1:0] buf_widx, buf_ridx;

  scc_chunk_ctrl #(
    .AW(AW), .BCW(BCW), .TW(TW), .ATW(ATW), .CMW(CMW),
    .BEAT_BYTES(BEAT_BYTES), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_ns),
    .q_empty      (q_empty),
    .hd_addr      (hd_addr),
    .hd_bcnt      (hd_bcnt),
    .hd_tag       (hd_tag),
    .hd_attr      (hd_attr),
    .hd_cmd       (hd_cmd),
    .q_pop        (q_pop),
    .be_cmd_valid (be_cmd_valid),
    .be_cmd_addr  (be_cmd_addr),
    .be_cmd_bcnt  (be_cmd_bcnt),
    .be_cmd_code  (be_cmd_code),
    .be_rd_valid  (be_rd_valid),
    .buf_we       (buf_we),
    .buf_widx     (buf_widx),
    .buf_ridx     (buf_ridx),
    .cpl_valid    (cpl_valid),
    .cpl_addr     (cpl_addr),
    .cpl_bcnt     (cpl_bcnt),
    .cpl_tag      (cpl_tag),
    .cpl_attr     (cpl_attr),
    .cpl_first    (cpl_first),
    .cpl_last     (cpl_last)
  );

  scc_chunk_buf #(.DW(DW), .DEPTH(CHUNK_BEATS)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .widx  (buf_widx),
    .wdata (be_rd_data),
    .ridx  (buf_ridx),
    .rdata (cpl_data)
  );

  // R3: accept and refuse never answer together
  p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    !(rsp_split && rsp_retry))
    else $error("split and retry together");

  // R1: an acceptance answers a request of the previous cycle
  p_split_has_req_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_split |-> $past(req_valid))
    else $error("split response without request");

  // R2: a refusal answers a request of the previous cycle
  p_retry_has_req_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_retry |-> $past(req_valid))
    else $error("retry response without request");

endmodule

// File: tb/sim_scc_split_chunker.sv
module sim_scc_split_chunker;
  localparam int CLK_PERIOD = 10;
  localparam int QD         = 4;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic        v;
    logic [31:0] addr;
    logic [12:0] bcnt;
    logic [4:0]  tag;
    logic [3:0]  attr;
    logic [3:0]  code;
  } stim_t;

  typedef struct packed {
    logic [31:0] addr;
    logic [12:0] bcnt;
    logic [3:0]  code;
  } cmd_t;

  typedef struct packed {
    logic [31:0] addr;
    logic [12:0] bcnt;
    logic [4:0]  tag;
    logic [3:0]  attr;
    logic        first;
    logic        last;
    logic        fin;
    logic [63:0] data;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [12:0] req_bcnt;
  logic [4:0]  req_tag;
  logic [3:0]  req_attr;
  logic [3:0]  req_cmd;
  logic        rsp_split, rsp_retry;
  logic        be_cmd_valid;
  logic [31:0] be_cmd_addr;
  logic [12:0] be_cmd_bcnt;
  logic [3:0]  be_cmd_code;
  logic        be_rd_valid;
  logic [63:0] be_rd_data;
  logic        cpl_valid;
  logic [31:0] cpl_addr;
  logic [12:0] cpl_bcnt;
  logic [4:0]  cpl_tag;
  logic [3:0]  cpl_attr;
  logic        cpl_first, cpl_last;
  logic [63:0] cpl_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  scc_split_chunker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_bcnt(req_bcnt),
    .req_tag(req_tag), .req_attr(req_attr), .req_cmd(req_cmd),
    .rsp_split(rsp_split), .rsp_retry(rsp_retry),
    .be_cmd_valid(be_cmd_valid), .be_cmd_addr(be_cmd_addr),
    .be_cmd_bcnt(be_cmd_bcnt), .be_cmd_code(be_cmd_code),
    .be_rd_valid(be_rd_valid), .be_rd_data(be_rd_data),
    .cpl_valid(cpl_valid), .cpl_addr(cpl_addr), .cpl_bcnt(cpl_bcnt),
    .cpl_tag(cpl_tag), .cpl_attr(cpl_attr), .cpl_first(cpl_first),
    .cpl_last(cpl_last), .cpl_data(cpl_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  stim_t stim_q[$];
  cmd_t  exp_cmd_q[$];
  beat_t exp_beat_q[$];

  logic        run = 1'b0;
  int          cyc = 0;
  int          occ = 0;
  logic        acc_prev = 1'b0, pop_prev = 1'b0;
  logic        es_prev = 1'b0, er_prev = 1'b0;
  logic        mid_prev = 1'b0;
  int          be_left = 0;
  int          be_delay = 0;
  logic [31:0] be_addr = '0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_C3C3, a};
  endfunction

  // expected backend reads and completion beats of one accepted request
  task automatic add_req(input stim_t s);
    logic [31:0] a;
    int rem, room, cl, nb;
    beat_t b;
    cmd_t  c;
    a = s.addr;
    rem = int'(s.bcnt);
    while (rem > 0) begin
      room = 1024 - int'(a % 1024);
      cl = (rem < room) ? rem : room;
      c.addr = a; c.bcnt = 13'(cl); c.code = s.code;
      exp_cmd_q.push_back(c);
      nb = cl / 8;
      for (int k = 0; k < nb; k++) begin
        b.addr  = a;
        b.bcnt  = 13'(cl);
        b.tag   = s.tag;
        b.attr  = s.attr;
        b.first = (k == 0);
        b.last  = (k == nb - 1);
        b.fin   = (k == nb - 1) && (rem == cl);
        b.data  = pat(a + 32'(8 * k));
        exp_beat_q.push_back(b);
      end
      a = a + 32'(cl);
      rem = rem - cl;
    end
  endtask

  task automatic put_req(input logic [31:0] a, input int n, input int t);
    stim_t s;
    s.v = 1'b1; s.addr = a; s.bcnt = 13'(n); s.tag = 5'(t);
    s.attr = 4'(t * 3); s.code = 4'(t + 1);
    stim_q.push_back(s);
  endtask

  task automatic put_idle(input int n);
    stim_t s;
    s = '0;
    for (int i = 0; i < n; i++) stim_q.push_back(s);
  endtask

  // reference model: outputs sampled and inputs driven at the falling edge
  always @(negedge clk) begin
    if (run) begin
      logic  pop_now;
      stim_t s;
      beat_t e;
      cmd_t  c;
      cyc++;
      pop_now = 1'b0;
      occ = occ + (acc_prev ? 1 : 0) - (pop_prev ? 1 : 0);

      chk(rsp_split == es_prev, "R1", "rsp_split", 64'(rsp_split), 64'(es_prev));
      chk(rsp_retry == er_prev, "R2", "rsp_retry", 64'(rsp_retry), 64'(er_prev));

      if (be_cmd_valid) begin
        chk(be_left == 0, "R4", "read issued with data outstanding", 64'(be_left), 64'd0);
        if (exp_cmd_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected backend read addr", 64'(be_cmd_addr), 64'd0);
        end else begin
          c = exp_cmd_q.pop_front();
          chk(be_cmd_addr == c.addr, "R6", "be_cmd_addr", 64'(be_cmd_addr), 64'(c.addr));
          chk(be_cmd_bcnt == c.bcnt, "R6", "be_cmd_bcnt", 64'(be_cmd_bcnt), 64'(c.bcnt));
          chk(be_cmd_code == c.code, "R4", "be_cmd_code", 64'(be_cmd_code), 64'(c.code));
        end
        be_addr  = be_cmd_addr;
        be_left  = int'(be_cmd_bcnt) / 8;
        be_delay = 2;
      end

      if (mid_prev) chk(cpl_valid, "R7", "beat missing inside completion", 64'(cpl_valid), 64'd1);
      if (cpl_valid) begin
        if (exp_beat_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected completion tag", 64'(cpl_tag), 64'd0);
        end else begin
          e = exp_beat_q.pop_front();
          if (cpl_first) chk(be_left == 0, "R5", "beats still owed at first completion beat", 64'(be_left), 64'd0);
          chk(cpl_tag == e.tag, "R8", "cpl_tag", 64'(cpl_tag), 64'(e.tag));
          chk(cpl_addr == e.addr, "R6", "cpl_addr", 64'(cpl_addr), 64'(e.addr));
          chk(cpl_bcnt == e.bcnt, "R10", "cpl_bcnt", 64'(cpl_bcnt), 64'(e.bcnt));
          chk(cpl_attr == e.attr, "R7", "cpl_attr", 64'(cpl_attr), 64'(e.attr));
          chk(cpl_first == e.first, "R7", "cpl_first", 64'(cpl_first), 64'(e.first));
          chk(cpl_last == e.last, "R7", "cpl_last", 64'(cpl_last), 64'(e.last));
          chk(cpl_data == e.data, "R7", "cpl_data", cpl_data, e.data);
          pop_now = e.fin;
        end
      end
      mid_prev = cpl_valid && !cpl_last;

      // backend model: fixed latency, one idle cycle in every four
      if (be_left > 0 && be_delay == 0 && (cyc % 4) != 3) begin
        be_rd_valid = 1'b1;
        be_rd_data  = pat(be_addr);
        be_addr     = be_addr + 32'd8;
        be_left--;
      end else begin
        be_rd_valid = 1'b0;
        be_rd_data  = '0;
      end
      if (be_delay > 0) be_delay--;

      s = (stim_q.size() != 0) ? stim_q.pop_front() : stim_t'('0);
      req_valid = s.v;
      req_addr  = s.addr;
      req_bcnt  = s.bcnt;
      req_tag   = s.tag;
      req_attr  = s.attr;
      req_cmd   = s.code;
      es_prev   = s.v && (occ < QD);
      er_prev   = s.v && (occ >= QD);
      if (es_prev) add_req(s);
      acc_prev  = es_prev;
      pop_prev  = pop_now;
    end
  end

  initial begin
    int waited;
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_bcnt = '0; req_tag = '0;
    req_attr = '0; req_cmd = '0; be_rd_valid = 1'b0; be_rd_data = '0;

    put_req(32'h0000_0100, 64, 1);     // R4: single chunk, inside region
    put_idle(60);
    put_req(32'h0000_03C0, 64, 2);     // R10: ends exactly on a boundary
    put_idle(60);
    put_req(32'h0000_0800, 1024, 3);   // R10: one whole aligned block
    put_idle(300);
    put_req(32'h0000_03F0, 32, 4);     // R6: crosses once, 16 + 16
    put_idle(60);
    put_req(32'h0000_11F8, 4096, 5);   // R6: first, three middle, last chunk
    put_req(32'h0000_2000, 64, 6);     // R8: queued behind the long one
    put_req(32'h0000_2400, 64, 7);
    put_req(32'h0000_2800, 64, 8);     // store now holds four
    put_req(32'h0000_2C00, 64, 9);     // R2: refused
    put_req(32'h0000_3000, 64, 10);    // R2: refused
    put_idle(1500);
    put_req(32'h0000_7FF8, 16, 11);    // R6: smallest crossing, 8 + 8
    put_req(32'h0000_4000, 8, 12);     // R7: one-beat completion
    put_idle(20);

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!rsp_split && !rsp_retry && !be_cmd_valid && !cpl_valid, "R9",
          "outputs during reset", {60'd0, rsp_split, rsp_retry, be_cmd_valid, cpl_valid}, 64'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rsp_split && !rsp_retry && !be_cmd_valid && !cpl_valid, "R9",
          "outputs after reset release", {60'd0, rsp_split, rsp_retry, be_cmd_valid, cpl_valid}, 64'd0);
    end
    run = 1'b1;

    waited = 0;
    while ((stim_q.size() != 0 || exp_beat_q.size() != 0 || exp_cmd_q.size() != 0 || be_left != 0)
           && waited < WATCHDOG) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= WATCHDOG) begin
      chk(1'b0, "R8", "watchdog expired, beats left", 64'(exp_beat_q.size()), 64'd0);
    end
    repeat (20) @(negedge clk);
    chk(exp_beat_q.size() == 0, "R8", "all accepted requests completed", 64'(exp_beat_q.size()), 64'd0);
    chk(!cpl_valid && !be_cmd_valid, "R2", "no activity after drain",
        {62'd0, cpl_valid, be_cmd_valid}, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule